// File: doc/BRIEF.md
# Latched-Address Binary Decoder

This block turns an N-bit binary select value into one of 2^N active-low select lines. The select value passes through a level-sensitive latch before it reaches the decoder. While the hold input is low, the latch is transparent and the active line follows the live select value. When the hold input rises, the value present at that moment is kept, and the select inputs are ignored until hold falls again.

A pair of output enables gates every line: one enable is active-high and the other is active-low. If either enable is inactive, all lines are forced high. The enables act only on the output stage. They neither load nor clear the held value, so a source can park a selection, blank the outputs, and bring the same line back later.

The block has no clock and no reset. Bit 0 of the select value is the least significant bit.

Top module: `latched_decoder`

## Requirements
- R1: With the outputs enabled, the line whose index equals the held select value is low and all other lines are high. `addr_i[0]` is the least significant bit, so for N=3 the value 3'b101 drives `sel_n_o[5]` low.
- R2: While `hold_i` is low, the latch is transparent, and a change on `addr_i` moves the low line to the new index.
- R3: On a rising edge of `hold_i`, the select value present at the edge is captured. Later changes on `addr_i` do not move the low line while `hold_i` stays high.
- R4: Whenever `oe_i` is low or `oe_n_i` is high, every bit of `sel_n_o` is high, whatever the select value and the hold state.
- R5: The enables do not load or clear the latch. After the latch closes and the enables are toggled, the same line as before goes low once the outputs are enabled again.
- R6: At no time is more than one bit of `sel_n_o` low.
- R7: The output width is 2^N for the parameter N, and R1 to R6 hold for N other than the default of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | N | Binary select value, bit 0 least significant |
| hold_i | input | 1 | Latch control: low makes the latch transparent, high holds the value |
| oe_i | input | 1 | Active-high output enable |
| oe_n_i | input | 1 | Active-low output enable |
| sel_n_o | output | 2^N | Active-low select lines |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default N=3 and the other uses N=4. The copies share the hold and enable inputs, and the 3-bit copy takes the low bits of the select value. The wider copy brings sixteen lines into reach, together with select values whose upper bit differs while the lower three bits agree. This shows that the decode uses every address bit and that the latch captures every bit.

// File: rtl/latched_decoder_pkg.sv
package latched_decoder_pkg;

  // Number of select lines for an address of the given width
  function automatic int unsigned line_count(input int unsigned width);
    return 32'd1 << width;
  endfunction

endpackage

// File: rtl/addr_hold_latch.sv
module addr_hold_latch #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] d_i,
  input  logic         hold_i,
  output logic [N-1:0] q_o
);

  // Level-sensitive: transparent while hold_i is low
  always_latch begin
    if (!hold_i) q_o = d_i;
  end

endmodule

// File: rtl/onehot_low_decoder.sv
module onehot_low_decoder #(
  parameter int unsigned N = 3,
  localparam int unsigned LINES = latched_decoder_pkg::line_count(N)
) (
  input  logic [N-1:0]     sel_i,
  output logic [LINES-1:0] dec_n_o
);

  function automatic logic [LINES-1:0] low_at(input logic [N-1:0] idx);
    logic [LINES-1:0] v;
    v = '1;
    v[idx] = 1'b0;
    return v;
  endfunction

  assign dec_n_o = low_at(sel_i);

endmodule

// File: rtl/line_gate.sv
module line_gate #(
  parameter int unsigned LINES = 8
) (
  input  logic [LINES-1:0] dec_n_i,
  input  logic             on_i,
  output logic [LINES-1:0] out_n_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign out_n_o[g] = on_i ? dec_n_i[g] : 1'b1;
  end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned N = 3,
  localparam int unsigned LINES = latched_decoder_pkg::line_count(N)
) (
  input  logic [N-1:0]     addr_i,
  input  logic             hold_i,
  input  logic             oe_i,
  input  logic             oe_n_i,
  output logic [LINES-1:0] sel_n_o
);

  logic [N-1:0]     held_addr;
  logic [LINES-1:0] dec_n;
  logic             outputs_on;

  assign outputs_on = oe_i & ~oe_n_i;

  addr_hold_latch #(.N(N)) u_latch (
    .d_i    (addr_i),
    .hold_i (hold_i),
    .q_o    (held_addr)
  );

  onehot_low_decoder #(.N(N)) u_dec (
    .sel_i   (held_addr),
    .dec_n_o (dec_n)
  );

  line_gate #(.LINES(LINES)) u_gate (
    .dec_n_i (dec_n),
    .on_i    (outputs_on),
    .out_n_o (sel_n_o)
  );

endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
  parameter int unsigned N = 3,
  localparam int unsigned LINES = latched_decoder_pkg::line_count(N)
) (
  input logic [N-1:0]     addr_i,
  input logic             hold_i,
  input logic             oe_i,
  input logic             oe_n_i,
  input logic [LINES-1:0] sel_n_o,
  input logic [N-1:0]     held_addr
);

  always_comb begin
    p_single_low_r6: assert ($onehot0(~sel_n_o))
      else $error("more than one line low");
    if (!oe_i || oe_n_i) begin
      p_forced_high_r4: assert (&sel_n_o)
        else $error("line low while disabled");
    end
    if (!hold_i) begin
      p_transparent_r2: assert (held_addr == addr_i)
        else $error("latch not following address while open");
    end
    if (oe_i && !oe_n_i) begin
      p_stored_line_r1: assert (!sel_n_o[held_addr] && $countones(~sel_n_o) == 1)
        else $error("enabled output does not match held value");
    end
  end

endmodule

bind latched_decoder latched_decoder_chk #(.N(N)) u_chk (
  .addr_i    (addr_i),
  .hold_i    (hold_i),
  .oe_i      (oe_i),
  .oe_n_i    (oe_n_i),
  .sel_n_o   (sel_n_o),
  .held_addr (held_addr)
);

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic [3:0] addr;
  logic       hold;
  logic       oe;
  logic       oe_n;
  logic [7:0]  out3;
  logic [15:0] out4;

  int   tests  = 0;
  int   fails  = 0;
  int   cycles = 0;
  bit   done   = 1'b0;
  logic [3:0] model_held;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_decoder #(.N(3)) u_dut (
    .addr_i (addr[2:0]), .hold_i (hold), .oe_i (oe), .oe_n_i (oe_n), .sel_n_o (out3)
  );

  latched_decoder #(.N(4)) u_dut4 (
    .addr_i (addr), .hold_i (hold), .oe_i (oe), .oe_n_i (oe_n), .sel_n_o (out4)
  );

  function automatic logic [15:0] expect_lines(input logic [3:0] held, input int width,
                                               input logic en, input logic en_n);
    logic [15:0] r;
    r = '1;
    if (en && !en_n) begin
      if (width == 3) r[held[2:0]] = 1'b0;
      else            r[held] = 1'b0;
    end
    if (width == 3) r[15:8] = 8'h00;
    return r;
  endfunction

  function automatic int lows(input logic [15:0] v, input int width);
    int c = 0;
    for (int i = 0; i < width; i++) if (!v[i]) c++;
    return c;
  endfunction

  // Drive inputs away from the clock edge, update the model, wait, then compare
  task automatic apply(input logic [3:0] a, input logic h, input logic e, input logic en_n,
                       input string tag);
    logic [15:0] e3, e4;
    @(negedge clk);
    addr = a; hold = h; oe = e; oe_n = en_n;
    if (!h) model_held = a;
    @(posedge clk);
    #1;
    e3 = expect_lines(model_held, 3, e, en_n);
    e4 = expect_lines(model_held, 4, e, en_n);
    tests++;
    if (out3 !== e3[7:0]) begin
      fails++;
      $display("FAIL %s N=3: got %b expected %b", tag, out3, e3[7:0]);
    end
    tests++;
    if (out4 !== e4) begin
      fails++;
      $display("FAIL %s N=4: got %b expected %b", tag, out4, e4);
    end
    tests++;
    if (lows({8'hFF, out3}, 8) > 1 || lows(out4, 16) > 1) begin
      fails++;
      $display("FAIL R6: got %0d/%0d low lines expected at most 1",
               lows({8'hFF, out3}, 8), lows(out4, 16));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] a;
    logic       h, prev_h, e, en_n;
    void'($urandom(32'd1234));
    addr = '0; hold = 1'b0; oe = 1'b0; oe_n = 1'b1; model_held = '0;

    // R4: first state, outputs disabled
    apply(4'd0, 1'b0, 1'b0, 1'b1, "R4 initial disabled");

    // R1: full decode sweep, transparent and enabled; value 5 -> line 5
    for (int i = 0; i < 16; i++) apply(4'(i), 1'b0, 1'b1, 1'b0, "R1 decode sweep");
    apply(4'b0101, 1'b0, 1'b1, 1'b0, "R1 lsb order 5");

    // R2: live following while open
    apply(4'd2, 1'b0, 1'b1, 1'b0, "R2 follow a");
    apply(4'd13, 1'b0, 1'b1, 1'b0, "R2 follow b");

    // R3: capture on rising hold, then ignore changes
    apply(4'd6, 1'b0, 1'b1, 1'b0, "R3 setup");
    apply(4'd6, 1'b1, 1'b1, 1'b0, "R3 capture");
    apply(4'd9, 1'b1, 1'b1, 1'b0, "R3 ignore a");
    apply(4'd15, 1'b1, 1'b1, 1'b0, "R3 ignore b");

    // R4: each enable alone forces all high, held state kept
    apply(4'd1, 1'b1, 1'b0, 1'b0, "R4 oe low");
    apply(4'd3, 1'b1, 1'b1, 1'b1, "R4 oe_n high");
    apply(4'd4, 1'b1, 1'b0, 1'b1, "R4 both off");

    // R5: enables toggled with latch closed, same line returns
    apply(4'd11, 1'b1, 1'b1, 1'b0, "R5 line returns");
    apply(4'd0, 1'b1, 1'b0, 1'b1, "R5 off again");
    apply(4'd7, 1'b1, 1'b1, 1'b0, "R5 line returns again");

    // R7: values that share low bits but differ in the top bit
    apply(4'b0011, 1'b0, 1'b1, 1'b0, "R7 upper bit clear");
    apply(4'b1011, 1'b0, 1'b1, 1'b0, "R7 upper bit set");
    apply(4'b1011, 1'b1, 1'b1, 1'b0, "R7 capture wide");
    apply(4'b0011, 1'b1, 1'b1, 1'b0, "R7 held wide");

    // R6 and mixed: random stimulus; address stays fixed on a rising hold
    prev_h = 1'b1;
    a = 4'b0011;
    for (int k = 0; k < 600; k++) begin
      h    = 1'($urandom_range(0, 1));
      e    = ($urandom_range(0, 3) != 0);
      en_n = ($urandom_range(0, 3) == 0);
      if (!(h && !prev_h)) a = 4'($urandom_range(0, 15));
      apply(a, h, e, en_n, "R6 random mix");
      prev_h = h;
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule